// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken by running two predictors side by side and letting a trained selector pick between them. The global side keeps a 12-bit record of the most recent branch outcomes and uses it to index a table of 2-bit saturating counters. The local side works in two levels. A table of 10-bit per-branch histories is indexed by instruction-address bits, and the selected history then indexes a table of 3-bit saturating counters. A third table of 2-bit selector counters, also indexed by the global record, decides which of the two answers is reported.

The fetch stage presents a word address on the predict port and reads the direction and the chosen source in the same cycle. The retire stage reports each resolved branch on the update port. That update trains both component counters, trains the selector when the components disagreed, and shifts the real outcome into both histories. History is kept non-speculatively. Recovery and target prediction belong to other blocks.

Top module: `tournament_bp`

## Requirements
- R1: After reset every local counter holds 3 and every global counter holds 1, which are the weakly-not-taken values. Every selector counter holds 1, which means weakly local. All histories are zero. Any address therefore predicts not taken with `pred_use_global` = 0.
- R2: `pred_use_global` equals the MSB of the selector counter at the current global history. `pred_taken` is the prediction of the component that the selector picks.
- R3: The local prediction is taken when its 3-bit counter is 4 or more. The counter moves up on taken and down on not taken, and it saturates at 0 and 7.
- R4: The local history entry is selected by PC bits 11:2. The predict and update address ports carry exactly those bits, with port bit 2 as the LSB. On an update, the entry shifts left and the outcome enters at bit 0.
- R5: The 12-bit global history shifts left on each update, and the newest outcome enters at bit 0.
- R6: The global prediction is the MSB of its 2-bit counter. On every update, the counter at the current global history is trained toward the outcome and saturates at 0 and 3.
- R7: The selector counter at the current global history changes only when the two component predictions differ. It steps up (toward global) when the global prediction matched the outcome, and down otherwise. It saturates at 0 and 3.
- R8: While `upd_valid` is low, no table and no history changes, whatever the other update inputs carry.
- R9: Prediction is combinational from the current state. An update in a cycle affects predictions only from the next cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pred_pc | input | 10 | Branch address bits 11:2 to predict |
| pred_taken | output | 1 | Predicted direction |
| pred_use_global | output | 1 | 1 when the global component supplied the prediction |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | 10 | Resolved branch address bits 11:2 |
| upd_taken | input | 1 | Actual outcome of the resolved branch |

## Verification
On every cycle, the assertions check the global history shift and the global history hold (R5, R8). They check the local history shift for back-to-back updates to one entry (R4). They also check that the predict-side read agrees with the update-side read whenever both address the same entry (R2).

Counter thresholds, saturation, selector training and reset values can only be shown by the bench's scenarios. Those scenarios drive outcome sequences whose resulting counter values were worked out by hand, and include a repeating pattern that only the global side can learn.

// File: rtl/tbp_pkg.sv
package tbp_pkg;
    localparam int INSTR_ALIGN = 2;

    typedef enum logic {
        SRC_LOCAL  = 1'b0,
        SRC_GLOBAL = 1'b1
    } src_e;
endpackage

// File: rtl/tbp_ctr_table.sv
module tbp_ctr_table #(
    parameter int IDX_W    = 12,
    parameter int CNT_W    = 2,
    parameter int INIT_VAL = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_hi,
    input  logic [IDX_W-1:0] up_idx,
    output logic             up_hi,
    input  logic             up_en,
    input  logic             up_inc
);
    localparam int               DEPTH    = 1 << IDX_W;
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(INIT_VAL);

    typedef struct packed {
        logic             we;
        logic [IDX_W-1:0] idx;
        logic [CNT_W-1:0] val;
    } wr_t;

    logic [CNT_W-1:0] cnt_q [DEPTH];
    logic [CNT_W-1:0] up_cnt;
    wr_t              wr_d;

    assign rd_hi  = cnt_q[rd_idx][CNT_W-1];
    assign up_cnt = cnt_q[up_idx];
    assign up_hi  = up_cnt[CNT_W-1];

    always_comb begin
        wr_d.we  = up_en;
        wr_d.idx = up_idx;
        wr_d.val = up_cnt;
        if (up_inc && (up_cnt != CNT_MAX)) begin
            wr_d.val = up_cnt + 1'b1;
        end else if (!up_inc && (up_cnt != '0)) begin
            wr_d.val = up_cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cnt_q[i] <= CNT_INIT;
            end
        end else if (wr_d.we) begin
            cnt_q[wr_d.idx] <= wr_d.val;
        end
    end
endmodule

// File: rtl/tbp_hist_table.sv
module tbp_hist_table #(
    parameter int IDX_W  = 10,
    parameter int HIST_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [HIST_W-1:0] rd_hist,
    input  logic [IDX_W-1:0]  up_idx,
    output logic [HIST_W-1:0] up_hist,
    input  logic              up_en,
    input  logic              up_bit
);
    localparam int DEPTH = 1 << IDX_W;

    typedef struct packed {
        logic              we;
        logic [IDX_W-1:0]  idx;
        logic [HIST_W-1:0] val;
    } wr_t;

    logic [HIST_W-1:0] hist_q [DEPTH];
    wr_t               wr_d;

    assign rd_hist = hist_q[rd_idx];
    assign up_hist = hist_q[up_idx];

    always_comb begin
        wr_d.we  = up_en;
        wr_d.idx = up_idx;
        wr_d.val = {up_hist[HIST_W-2:0], up_bit};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                hist_q[i] <= '0;
            end
        end else if (wr_d.we) begin
            hist_q[wr_d.idx] <= wr_d.val;
        end
    end
endmodule

// File: rtl/tournament_bp.sv
module tournament_bp
    import tbp_pkg::*;
#(
    parameter  int GHIST_W   = 12,
    parameter  int LHT_IDX_W = 10,
    parameter  int LHIST_W   = 10,
    parameter  int LCNT_W    = 3,
    parameter  int GCNT_W    = 2,
    parameter  int SEL_W     = 2,
    localparam int PC_HI     = INSTR_ALIGN + LHT_IDX_W - 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [PC_HI:INSTR_ALIGN] pred_pc,
    output logic                   pred_taken,
    output logic                   pred_use_global,
    input  logic                   upd_valid,
    input  logic [PC_HI:INSTR_ALIGN] upd_pc,
    input  logic                   upd_taken
);
    localparam int LCNT_INIT = (1 << (LCNT_W - 1)) - 1;
    localparam int GCNT_INIT = (1 << (GCNT_W - 1)) - 1;
    localparam int SEL_INIT  = (1 << (SEL_W - 1)) - 1;

    typedef struct packed {
        logic [GHIST_W-1:0] ghist;
    } gstate_t;

    gstate_t            state_d, state_q;
    logic [GHIST_W-1:0] ghist_q;

    logic [LHIST_W-1:0] pred_lhist, upd_lhist;
    logic               pred_loc_hi, pred_glob_hi, pred_sel_hi;
    logic               upd_loc_hi, upd_glob_hi, upd_sel_hi;
    logic               sel_train, sel_toward_global;
    src_e               pred_src;

    assign ghist_q = state_q.ghist;

    tbp_hist_table #(.IDX_W(LHT_IDX_W), .HIST_W(LHIST_W)) u_lht (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (pred_pc),
        .rd_hist (pred_lhist),
        .up_idx  (upd_pc),
        .up_hist (upd_lhist),
        .up_en   (upd_valid),
        .up_bit  (upd_taken)
    );

    tbp_ctr_table #(.IDX_W(LHIST_W), .CNT_W(LCNT_W), .INIT_VAL(LCNT_INIT)) u_lct (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (pred_lhist),
        .rd_hi  (pred_loc_hi),
        .up_idx (upd_lhist),
        .up_hi  (upd_loc_hi),
        .up_en  (upd_valid),
        .up_inc (upd_taken)
    );

    tbp_ctr_table #(.IDX_W(GHIST_W), .CNT_W(GCNT_W), .INIT_VAL(GCNT_INIT)) u_gct (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (ghist_q),
        .rd_hi  (pred_glob_hi),
        .up_idx (ghist_q),
        .up_hi  (upd_glob_hi),
        .up_en  (upd_valid),
        .up_inc (upd_taken)
    );

    assign sel_train         = upd_valid && (upd_loc_hi != upd_glob_hi);
    assign sel_toward_global = (upd_glob_hi == upd_taken);

    tbp_ctr_table #(.IDX_W(GHIST_W), .CNT_W(SEL_W), .INIT_VAL(SEL_INIT)) u_sel (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (ghist_q),
        .rd_hi  (pred_sel_hi),
        .up_idx (ghist_q),
        .up_hi  (upd_sel_hi),
        .up_en  (sel_train),
        .up_inc (sel_toward_global)
    );

    always_comb begin
        pred_src        = pred_sel_hi ? SRC_GLOBAL : SRC_LOCAL;
        pred_use_global = (pred_src == SRC_GLOBAL);
        pred_taken      = (pred_src == SRC_GLOBAL) ? pred_glob_hi : pred_loc_hi;
    end

    always_comb begin
        state_d = state_q;
        if (upd_valid) begin
            state_d.ghist = {state_q.ghist[GHIST_W-2:0], upd_taken};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end
endmodule

// File: rtl/tournament_bp_chk.sv
module tournament_bp_chk #(
    parameter int GHIST_W   = 12,
    parameter int LHT_IDX_W = 10,
    parameter int LHIST_W   = 10
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [LHT_IDX_W-1:0] pred_idx,
    input logic [LHT_IDX_W-1:0] upd_idx,
    input logic                 upd_valid,
    input logic                 upd_taken,
    input logic                 pred_taken,
    input logic [GHIST_W-1:0]   ghist_q,
    input logic [LHIST_W-1:0]   upd_lhist,
    input logic                 upd_loc_hi,
    input logic                 upd_glob_hi,
    input logic                 upd_sel_hi
);
    logic                   prev_valid_q;
    logic [LHT_IDX_W-1:0]   prev_idx_q;
    logic [LHIST_W-2:0]     prev_lhist_q;
    logic                   prev_taken_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_valid_q <= 1'b0;
            prev_idx_q   <= '0;
            prev_lhist_q <= '0;
            prev_taken_q <= 1'b0;
        end else begin
            prev_valid_q <= upd_valid;
            prev_idx_q   <= upd_idx;
            prev_lhist_q <= upd_lhist[LHIST_W-2:0];
            prev_taken_q <= upd_taken;
        end
    end

    AST_GHIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> ghist_q == {$past(ghist_q[GHIST_W-2:0]), $past(upd_taken)}); // R5

    AST_GHIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> $stable(ghist_q)); // R8

    AST_LHIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && prev_valid_q && (upd_idx == prev_idx_q))
        |-> upd_lhist == {prev_lhist_q, prev_taken_q}); // R4

    AST_PORT_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && (pred_idx == upd_idx))
        |-> pred_taken == (upd_sel_hi ? upd_glob_hi : upd_loc_hi)); // R2
endmodule

bind tournament_bp tournament_bp_chk #(
    .GHIST_W   (GHIST_W),
    .LHT_IDX_W (LHT_IDX_W),
    .LHIST_W   (LHIST_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pred_idx    (pred_pc),
    .upd_idx     (upd_pc),
    .upd_valid   (upd_valid),
    .upd_taken   (upd_taken),
    .pred_taken  (pred_taken),
    .ghist_q     (ghist_q),
    .upd_lhist   (upd_lhist),
    .upd_loc_hi  (upd_loc_hi),
    .upd_glob_hi (upd_glob_hi),
    .upd_sel_hi  (upd_sel_hi)
);

// File: tb/tournament_bp_test.sv
`timescale 1ns/1ps
module tournament_bp_test;
    localparam int IW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [IW-1:0] pred_pc = '0;
    logic          pred_taken;
    logic          pred_use_global;
    logic          upd_valid = 1'b0;
    logic [IW-1:0] upd_pc = '0;
    logic          upd_taken = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;

    localparam logic [IW-1:0] PA = 10'h040;
    localparam logic [IW-1:0] PB = 10'h080;
    localparam logic [IW-1:0] PC = 10'h0C0;
    localparam logic [IW-1:0] PD = 10'h100;
    localparam logic [IW-1:0] PP = 10'h140;

    always #2.5 clk = ~clk;

    tournament_bp uut (
        .clk             (clk),
        .rst_n           (rst_n),
        .pred_pc         (pred_pc),
        .pred_taken      (pred_taken),
        .pred_use_global (pred_use_global),
        .upd_valid       (upd_valid),
        .upd_pc          (upd_pc),
        .upd_taken       (upd_taken)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        upd_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic update(input logic [IW-1:0] pc, input logic t);
        @(negedge clk);
        upd_valid = 1'b1;
        upd_pc    = pc;
        upd_taken = t;
        @(posedge clk);
        #1 upd_valid = 1'b0;
    endtask

    task automatic train(input logic [IW-1:0] pc, input logic t, input int n);
        for (int i = 0; i < n; i++) update(pc, t);
    endtask

    task automatic probe(input logic [IW-1:0] pc, input logic exp_t, input logic exp_g, input string req);
        @(negedge clk);
        pred_pc = pc;
        #1;
        chk(req, "pred_taken", pred_taken, exp_t);
        chk(req, "pred_use_global", pred_use_global, exp_g);
    endtask

    // R1: reset state predicts not taken from the local side everywhere
    task automatic t_reset();
        do_reset();
        probe(10'h000, 1'b0, 1'b0, "R1");
        probe(PA,      1'b0, 1'b0, "R1");
        probe(10'h3FF, 1'b0, 1'b0, "R1");
        probe(10'h28D, 1'b0, 1'b0, "R1");
    endtask

    // R3 threshold, R4 per-entry index, R8 ignored updates, R9 same-cycle timing
    task automatic t_threshold();
        do_reset();
        train(PA, 1'b1, 10);
        probe(PA, 1'b0, 1'b0, "R3 counter at 3");
        probe(PA + 10'd1, 1'b1, 1'b0, "R4 neighbour entry uses counter 0");
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            upd_valid = 1'b0;
            upd_pc    = PA;
            upd_taken = 1'b1;
        end
        probe(PA, 1'b0, 1'b0, "R8 invalid update ignored");
        @(negedge clk);
        upd_valid = 1'b1;
        upd_pc    = PA;
        upd_taken = 1'b1;
        pred_pc   = PA;
        #1 chk("R9", "pred before edge", pred_taken, 1'b0);
        @(posedge clk);
        #1 upd_valid = 1'b0;
        #1 chk("R9", "pred after edge", pred_taken, 1'b1);
        probe(PA, 1'b1, 1'b0, "R3 counter at 4");
    endtask

    // R3 saturation at 7, R7 selector stays local
    task automatic t_saturate();
        do_reset();
        train(PA, 1'b1, 20);
        probe(PA, 1'b1, 1'b0, "R7 selector moved toward local");
        train(PB, 1'b1, 10);
        train(PC, 1'b1, 10);
        train(PD, 1'b1, 10);
        update(PA, 1'b0);
        update(PB, 1'b0);
        update(PC, 1'b0);
        probe(PD, 1'b1, 1'b0, "R3 saturated counter after three decrements");
    endtask

    // R2, R5, R6, R7: period-12 pattern learnt only by the global side
    task automatic t_global_wins();
        do_reset();
        for (int p = 0; p < 5; p++) begin
            train(PP, 1'b1, 11);
            update(PP, 1'b0);
        end
        train(PP, 1'b1, 10);
        probe(PP, 1'b1, 1'b1, "R7 R6 global chosen before eleventh taken");
        update(PP, 1'b1);
        probe(PP, 1'b0, 1'b1, "R2 R5 global chosen before not taken");
    endtask

    initial begin
        #500000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_threshold();
        t_saturate();
        t_global_wins();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule